// File: doc/BRIEF.md
# Push-Button Debouncer with Immediate Rise and Masking Timer

This block turns the contact-bounce of a mechanical push-button into one clean logic level. The raw pin first passes through a flop-chain synchronizer. A small control state machine then raises the clean level on the first sign of a press. It does not wait for the pin to settle. Instead it starts a separate masking timer, and every transition on the pin is ignored until that timer expires.

When the masking window ends, the machine looks at the synchronized pin once. If the button is already released, it returns to rest. If the button is still down, it moves to a hold state. In the hold state the level stays high and the timer is off until the button is let go.

The states are named `ST_IDLE` (level low, timer off), `ST_TIMING` (level high, timer counting) and `ST_HELD` (level high, timer off). The transitions are:

- **press**: `ST_IDLE` to `ST_TIMING`, when the synchronized pin is 1.
- **expire-released**: `ST_TIMING` to `ST_IDLE`, when the window ends with the pin at 0.
- **expire-held**: `ST_TIMING` to `ST_HELD`, when the window ends with the pin at 1.
- **release**: `ST_HELD` to `ST_IDLE`, when the pin is 0.

The length of the window is the parameter `HOLD_CYCLES`.

Top module: `btn_debounce`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) forces `level_o` and `timer_en_o` to 0 after that edge, including when the reset arrives during a masking window.
- R2: From rest, the first clock edge that samples `button_i` at 1 leads to `level_o` being 1 after the fourth edge counted from it. Edges 1 and 2 are synchronizer stages, edge 3 is the state change and edge 4 is the output register. Before that, `level_o` stays 0.
- R3: While in `ST_TIMING`, `level_o` stays 1 and `timer_en_o` stays 1, whatever `button_i` does.
- R4: If the synchronized pin is 0 when the window expires (the **expire-released** transition), `level_o` falls. A press whose first sampled edge is edge 0 keeps `level_o` high after edges 3 through HOLD_CYCLES+5 and low from edge HOLD_CYCLES+6.
- R5: If the synchronized pin is 1 when the window expires (the **expire-held** transition), the block enters `ST_HELD`. There `level_o` stays 1 and `timer_en_o` is 0 for as long as the button stays down.
- R6: In `ST_HELD`, a release whose first 0 is sampled at edge r drops `level_o` after edge r+3.
- R7: The timer counter is cleared while disabled. While enabled it counts up to HOLD_CYCLES and then raises its done flag. For every masking window, `timer_en_o` is high for exactly HOLD_CYCLES+3 consecutive cycles.
- R8: A press that re-enters `ST_TIMING` one cycle after an **expire-released** transition still gets a full window of HOLD_CYCLES+3 enabled cycles. The done flag left over from the previous window is never acted upon.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| button_i | input | 1 | Raw, asynchronous, bouncing button pin (1 = pressed) |
| level_o | output | 1 | Debounced level, registered |
| timer_en_o | output | 1 | Masking-timer enable, registered, brought out for test |

## Verification
The bench drives bounce bursts inside the masking window and checks that the level never dips. A design that sampled the pin during `ST_TIMING` would show a gap in `level_o`. It lines up a release and re-press exactly at the expiry edge. A design that acted on the stale done flag would leave the second window after one cycle, and the enable pulse would come out far too short. Latency is checked edge by edge on press and on release, so a missing or extra register stage in the synchronizer or output path appears as a one-cycle shift. A reset in the middle of a window checks that both outputs clear at once.

// File: rtl/btn_debounce_pkg.sv
package btn_debounce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TIMING = 2'd1,
        ST_HELD   = 2'd2
    } deb_state_e;

endpackage

// File: rtl/deb_sync.sv
module deb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/deb_timer.sv
module deb_timer #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic done_o
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (cnt_q < LIMIT) begin
            cnt_q  <= cnt_q + 1'b1;
        end else begin
            done_q <= 1'b1;
        end
    end

    assign done_o = done_q;

    // R7: a disabled timer holds a cleared count and flag
    a_r7_clear_when_off: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (cnt_q == '0 && !done_q));

    // R7: the count never passes the limit
    a_r7_no_overrun: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LIMIT);

    // R7: the flag is only ever seen with a full count
    a_r7_done_at_limit: assert property (@(posedge clk_i) disable iff (rst_i)
        done_q |-> cnt_q == LIMIT);

endmodule

// File: rtl/deb_fsm.sv
module deb_fsm
    import btn_debounce_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic btn_sync_i,
    input  logic done_i,
    output logic level_o,
    output logic timer_en_o
);

    deb_state_e state_q, state_d;
    logic       level_q, en_q;
    logic       expired;

    // Only trust the flag once the enable has reached the timer; this
    // blocks a stale flag left over from the previous window.
    assign expired = done_i & en_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (btn_sync_i) state_d = ST_TIMING;
            end
            ST_TIMING: begin
                if (expired) state_d = btn_sync_i ? ST_HELD : ST_IDLE;
            end
            ST_HELD: begin
                if (!btn_sync_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // Registered outputs, one clock behind the state
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            level_q <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            level_q <= (state_q != ST_IDLE);
            en_q    <= (state_q == ST_TIMING);
        end
    end

    assign level_o    = level_q;
    assign timer_en_o = en_q;

    // R2: rest is kept while the synchronized pin is low
    a_r2_idle_waits: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && !btn_sync_i) |=> state_q == ST_IDLE);

    // R3: the level is high one cycle after any active state
    a_r3_level_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_IDLE) |=> level_q);

    // R5: the timer is never enabled out of the hold state
    a_r5_held_timer_off: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_HELD) |=> !en_q);

    // R8: a freshly entered window cannot end before its enable lands
    a_r8_no_early_exit: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_TIMING && !en_q) |=> state_q == ST_TIMING);

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int HOLD_CYCLES = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic button_i,
    output logic level_o,
    output logic timer_en_o
);

    logic btn_sync;
    logic tmr_done;
    logic tmr_en;

    deb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .async_i(button_i),
        .sync_o (btn_sync)
    );

    deb_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .btn_sync_i(btn_sync),
        .done_i    (tmr_done),
        .level_o   (level_o),
        .timer_en_o(tmr_en)
    );

    deb_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (tmr_en),
        .done_o(tmr_done)
    );

    assign timer_en_o = tmr_en;

    // R1: the outputs are cleared on the edge after a reset
    a_r1_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (!level_o && !timer_en_o));

endmodule

// File: tb/btn_debounce_test.sv
`timescale 1ns/1ps
module btn_debounce_test;

    localparam int T = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn = 1'b0;
    logic level, ten;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    btn_debounce #(.HOLD_CYCLES(T), .SYNC_STAGES(2)) uut (
        .clk_i     (clk),
        .rst_i     (rst),
        .button_i  (btn),
        .level_o   (level),
        .timer_en_o(ten)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic settle();
        btn = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "level in reset", level, 1'b0);
        chk("R1", "enable in reset", ten, 1'b0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // R2 R3 R4 R7: short press with bounces, released before expiry
    task automatic t_short_press();
        int en_cnt = 0;
        for (int i = 0; i <= T + 10; i++) begin
            btn = (i == 0 || i == 1 || i == 3 || i == 5);
            @(negedge clk);
            if (i < 3) chk("R2", "level before latency", level, 1'b0);
            else if (i <= T + 5) chk("R3", "level held in window", level, 1'b1);
            else chk("R4", "level after expiry", level, 1'b0);
            chk("R3", "enable in window", ten, (i >= 3 && i <= T + 5));
            if (ten) en_cnt++;
        end
        n_checks++;
        if (en_cnt != T + 3) begin
            n_fail++;
            $display("FAIL R7 enable length: got %0d expected %0d", en_cnt, T + 3);
        end
    endtask

    // R5 R6: held past expiry, then clean release
    task automatic t_held();
        int r = T + 15;
        for (int i = 0; i <= r + 6; i++) begin
            btn = (i < r) && !(i == 2 || i == 4);
            @(negedge clk);
            if (i >= 3 && i <= r + 2) chk("R5", "level while down", level, 1'b1);
            if (i >= r + 3) chk("R6", "level after release", level, 1'b0);
            if (i > T + 5 && i < r) chk("R5", "enable off in hold", ten, 1'b0);
        end
    endtask

    // R8: release then re-press lined up with expiry
    task automatic t_repress();
        int en_cnt2 = 0;
        for (int i = 0; i <= 2 * T + 14; i++) begin
            btn = (i != T + 3);
            @(negedge clk);
            if (i >= 3 && i <= T + 5) chk("R8", "first level", level, 1'b1);
            if (i == T + 6) chk("R8", "level gap", level, 1'b0);
            if (i >= T + 7) chk("R8", "second level", level, 1'b1);
            if (i >= T + 6 && ten) en_cnt2++;
        end
        n_checks++;
        if (en_cnt2 != T + 3) begin
            n_fail++;
            $display("FAIL R8 second window length: got %0d expected %0d", en_cnt2, T + 3);
        end
    endtask

    // R1: reset during a masking window
    task automatic t_mid_reset();
        btn = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1", "level before mid reset", level, 1'b1);
        rst = 1'b1;
        btn = 1'b0;
        @(negedge clk);
        chk("R1", "level after mid reset", level, 1'b0);
        chk("R1", "enable after mid reset", ten, 1'b0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "stays at rest", level, 1'b0);
    endtask

    initial begin
        t_reset();
        settle();
        t_short_press();
        settle();
        t_held();
        settle();
        t_repress();
        settle();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule